// File: doc/BRIEF.md
# Comparator Offset Trim Sequencer

This block is the digital controller that removes the input offset of a dynamic comparator before the converter around it starts normal work. On a start request it grounds both auxiliary trim devices by forcing the trim code to zero with neither side selected. It also asserts a select that ties both comparator inputs to one common-mode level. It then asks the comparator for a decision. That first decision fixes which side of the comparator receives the trim drive.

From then on the controller raises the trim code one step at a time, with one comparison per step. It stops at the first comparison whose decision differs from the first one. The search is a monotonic step-up, not a binary search. When the decision reverses, the controller drops the side select and the common-mode select, freezes the code and raises a done flag. If the code reaches full scale without a reversal, calibration still ends, and a saturation flag is raised next to done.

The comparator is clocked by a one-cycle request from the controller and answers with a valid strobe some cycles later. The controller reads the comparator's differential outputs only on that strobe, and only while it is waiting for an answer.

Top module: `cmp_trim_ctrl`

## Requirements
- R1: While reset is asserted, and afterwards until the first start, the trim code is 0 and the done, saturation, request, common-mode and both side-select outputs are 0.
- R2: A start pulse seen in the idle or finished state clears done and saturation, sets the trim code to 0 with neither side selected, asserts the common-mode select, and then issues one comparator request with the code still 0.
- R3: The first valid decision selects the side. A decision of positive output 1 and negative output 0 selects the negative-side trim (trim_sel_neg_o). Any other output pair selects the positive side (trim_sel_pos_o). Both side selects are never high together.
- R4: Each valid decision equal to the first one raises the trim code by exactly 1 and issues one new comparator request, so each code value from 0 up to the final code is compared exactly once.
- R5: The first valid decision that differs from the first one ends calibration. done goes high, both side selects and the common-mode select go low, saturation stays 0, and the code keeps the value at which the decision differed.
- R6: After calibration ends, the trim code, done and saturation keep their values until the next start, whatever the comparator outputs and valid strobe do.
- R7: If the decision at code 63 (full scale of the 6-bit code) still equals the first one, calibration ends with done and saturation both 1 and the code at 63.
- R8: Comparator outputs change nothing unless the valid strobe is high while the controller is waiting for an answer to its request.
- R9: A start pulse during a calibration in progress has no effect on it.
- R10: The comparator request is a single-cycle pulse and is asserted only while the common-mode select is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cal_start_i | input | 1 | Start request pulse |
| cmp_valid_i | input | 1 | Comparator answer strobe |
| cmp_outp_i | input | 1 | Comparator positive decision output |
| cmp_outn_i | input | 1 | Comparator negative decision output |
| cmp_req_o | output | 1 | One-cycle comparator clock request |
| short_inputs_o | output | 1 | Tie both comparator inputs to common mode |
| trim_sel_pos_o | output | 1 | Connect trim drive to the positive-side auxiliary device |
| trim_sel_neg_o | output | 1 | Connect trim drive to the negative-side auxiliary device |
| trim_code_o | output | CODE_W | Trim step code driving the calibration DAC |
| cal_done_o | output | 1 | Calibration finished, code frozen |
| cal_sat_o | output | 1 | Calibration ended at full scale without reversal |

## Verification
The assertions check on every cycle that the side selects are mutually exclusive, that the code only ever moves up by one or returns to zero, and that a finished calibration has released the drive and holds its code. They also check that saturation implies full-scale code and that requests are single pulses issued under common-mode select. Only the bench's scenarios can show the search itself: which side an offset picks, at which code the reversal lands, and how many requests were spent. A comparator model with a programmable offset, swept across both signs and past full scale, shows these. The bench puts contrary data on the outputs outside valid strobes, to show that non-strobed data is ignored.

// File: rtl/cmp_trim_pkg.sv
package cmp_trim_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CLEAR,
        ST_FIRST,
        ST_STEP,
        ST_CHECK,
        ST_DONE
    } trim_state_e;

endpackage

// File: rtl/cmp_trim_qual.sv
module cmp_trim_qual (
    input  logic valid_i,
    input  logic outp_i,
    input  logic outn_i,
    input  logic waiting_i,
    output logic take_o,
    output logic dec_hi_o
);

    // A decision counts only on a strobe while an answer is awaited.
    always_comb begin
        take_o   = valid_i && waiting_i;
        dec_hi_o = outp_i && !outn_i;
    end

endmodule

// File: rtl/cmp_trim_core.sv
module cmp_trim_core
    import cmp_trim_pkg::*;
#(
    parameter int CODE_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              take_i,
    input  logic              dec_hi_i,
    output logic              waiting_o,
    output logic              req_o,
    output logic              short_o,
    output logic              sel_pos_o,
    output logic              sel_neg_o,
    output logic [CODE_W-1:0] code_o,
    output logic              done_o,
    output logic              sat_o
);

    localparam logic [CODE_W-1:0] CODE_MAX = {CODE_W{1'b1}};

    typedef struct packed {
        trim_state_e       state;
        logic [CODE_W-1:0] code;
        logic              sel_pos;
        logic              sel_neg;
        logic              short_in;
        logic              req;
        logic              done;
        logic              sat;
        logic              first_hi;
    } core_s;

    localparam core_s CORE_RST = '{
        state:    ST_IDLE,
        code:     '0,
        sel_pos:  1'b0,
        sel_neg:  1'b0,
        short_in: 1'b0,
        req:      1'b0,
        done:     1'b0,
        sat:      1'b0,
        first_hi: 1'b0
    };

    core_s r_d, r_q;

    always_comb begin
        r_d     = r_q;
        r_d.req = 1'b0;
        unique case (r_q.state)
            ST_IDLE, ST_DONE: begin
                if (start_i) begin
                    r_d.state    = ST_CLEAR;
                    r_d.code     = '0;
                    r_d.sel_pos  = 1'b0;
                    r_d.sel_neg  = 1'b0;
                    r_d.short_in = 1'b1;
                    r_d.done     = 1'b0;
                    r_d.sat      = 1'b0;
                end
            end
            ST_CLEAR: begin
                r_d.state = ST_FIRST;
                r_d.req   = 1'b1;
            end
            ST_FIRST: begin
                if (take_i) begin
                    r_d.first_hi = dec_hi_i;
                    r_d.sel_neg  = dec_hi_i;
                    r_d.sel_pos  = !dec_hi_i;
                    r_d.state    = ST_STEP;
                end
            end
            ST_STEP: begin
                if (r_q.code == CODE_MAX) begin
                    r_d.state    = ST_DONE;
                    r_d.done     = 1'b1;
                    r_d.sat      = 1'b1;
                    r_d.sel_pos  = 1'b0;
                    r_d.sel_neg  = 1'b0;
                    r_d.short_in = 1'b0;
                end else begin
                    r_d.code  = r_q.code + 1'b1;
                    r_d.state = ST_CHECK;
                    r_d.req   = 1'b1;
                end
            end
            ST_CHECK: begin
                if (take_i) begin
                    if (dec_hi_i != r_q.first_hi) begin
                        r_d.state    = ST_DONE;
                        r_d.done     = 1'b1;
                        r_d.sel_pos  = 1'b0;
                        r_d.sel_neg  = 1'b0;
                        r_d.short_in = 1'b0;
                    end else begin
                        r_d.state = ST_STEP;
                    end
                end
            end
            default: r_d = CORE_RST;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= CORE_RST;
        else        r_q <= r_d;
    end

    always_comb begin
        waiting_o = (r_q.state == ST_FIRST) || (r_q.state == ST_CHECK);
        req_o     = r_q.req;
        short_o   = r_q.short_in;
        sel_pos_o = r_q.sel_pos;
        sel_neg_o = r_q.sel_neg;
        code_o    = r_q.code;
        done_o    = r_q.done;
        sat_o     = r_q.sat;
    end

endmodule

// File: rtl/cmp_trim_ctrl.sv
module cmp_trim_ctrl #(
    parameter int CODE_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cal_start_i,
    input  logic              cmp_valid_i,
    input  logic              cmp_outp_i,
    input  logic              cmp_outn_i,
    output logic              cmp_req_o,
    output logic              short_inputs_o,
    output logic              trim_sel_pos_o,
    output logic              trim_sel_neg_o,
    output logic [CODE_W-1:0] trim_code_o,
    output logic              cal_done_o,
    output logic              cal_sat_o
);

    logic waiting;
    logic take;
    logic dec_hi;

    cmp_trim_qual u_qual (
        .valid_i   (cmp_valid_i),
        .outp_i    (cmp_outp_i),
        .outn_i    (cmp_outn_i),
        .waiting_i (waiting),
        .take_o    (take),
        .dec_hi_o  (dec_hi)
    );

    cmp_trim_core #(.CODE_W(CODE_W)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (cal_start_i),
        .take_i    (take),
        .dec_hi_i  (dec_hi),
        .waiting_o (waiting),
        .req_o     (cmp_req_o),
        .short_o   (short_inputs_o),
        .sel_pos_o (trim_sel_pos_o),
        .sel_neg_o (trim_sel_neg_o),
        .code_o    (trim_code_o),
        .done_o    (cal_done_o),
        .sat_o     (cal_sat_o)
    );

endmodule

// File: rtl/cmp_trim_chk.sv
module cmp_trim_chk #(
    parameter int CODE_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cal_start_i,
    input logic              cmp_req_o,
    input logic              short_inputs_o,
    input logic              trim_sel_pos_o,
    input logic              trim_sel_neg_o,
    input logic [CODE_W-1:0] trim_code_o,
    input logic              cal_done_o,
    input logic              cal_sat_o
);

    localparam logic [CODE_W-1:0] FULL = {CODE_W{1'b1}};

    // R3
    one_side_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(trim_sel_pos_o && trim_sel_neg_o));

    // R4
    code_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trim_code_o != $past(trim_code_o)) |->
            ((trim_code_o - $past(trim_code_o)) == CODE_W'(1) || trim_code_o == '0));

    // R5
    release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cal_done_o |-> (!trim_sel_pos_o && !trim_sel_neg_o && !short_inputs_o));

    // R6
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cal_done_o && !cal_start_i) |=> ($stable(trim_code_o) && cal_done_o && $stable(cal_sat_o)));

    // R7
    sat_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cal_sat_o |-> (trim_code_o == FULL && cal_done_o));

    // R10
    req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_req_o |=> !cmp_req_o);

    // R10
    req_short_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_req_o |-> short_inputs_o);

endmodule

bind cmp_trim_ctrl cmp_trim_chk #(.CODE_W(CODE_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .cal_start_i    (cal_start_i),
    .cmp_req_o      (cmp_req_o),
    .short_inputs_o (short_inputs_o),
    .trim_sel_pos_o (trim_sel_pos_o),
    .trim_sel_neg_o (trim_sel_neg_o),
    .trim_code_o    (trim_code_o),
    .cal_done_o     (cal_done_o),
    .cal_sat_o      (cal_sat_o)
);

// File: tb/cmp_trim_ctrl_tb_top.sv
`timescale 1ns/1ps
module cmp_trim_ctrl_tb_top;

    localparam int CW   = 6;
    localparam int FULL = (1 << CW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          valid = 1'b0;
    logic          outp = 1'b0;
    logic          outn = 1'b0;
    logic          req, shrt, spos, sneg, done, sat;
    logic [CW-1:0] code;

    int vectors = 0;
    int misses  = 0;

    int offset    = 0;
    int pend      = 0;
    int req_count = 0;
    bit saw_pos   = 0;
    bit saw_neg   = 0;
    bit short_gap = 0;
    bit noise_en  = 0;

    always #4 clk = ~clk;

    cmp_trim_ctrl #(.CODE_W(CW)) dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .cal_start_i    (start),
        .cmp_valid_i    (valid),
        .cmp_outp_i     (outp),
        .cmp_outn_i     (outn),
        .cmp_req_o      (req),
        .short_inputs_o (shrt),
        .trim_sel_pos_o (spos),
        .trim_sel_neg_o (sneg),
        .trim_code_o    (code),
        .cal_done_o     (done),
        .cal_sat_o      (sat)
    );

    // Comparator model: effective offset seen with the present trim drive.
    function automatic bit model_hi();
        int eff;
        eff = offset;
        if (spos) eff = eff + int'(code);
        if (sneg) eff = eff - int'(code);
        return eff > 0;
    endfunction

    always @(negedge clk) begin
        bit m;
        m = model_hi();
        valid <= 1'b0;
        outp  <= !m;           // contrary data whenever no strobe (R8)
        outn  <= m;
        if (pend == 1) begin
            valid <= 1'b1;
            outp  <= m;
            outn  <= !m;
        end else if (noise_en) begin
            valid <= 1'b1;
            outp  <= ($urandom & 1) != 0;
            outn  <= ($urandom & 1) != 0;
        end
        if (pend != 0) pend = pend - 1;
        if (req) begin
            pend      = 3;
            req_count = req_count + 1;
        end
        if (spos) saw_pos = 1;
        if (sneg) saw_neg = 1;
        if ((spos || sneg) && !shrt) short_gap = 1;
    end

    task automatic check(input string tag, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            misses++;
            $display("FAIL %s offset=%0d actual=%0d expected=%0d", tag, offset, act, exp);
        end
    endtask

    task automatic run_one(input int off, input bit poke_start);
        int exp_code, exp_cmp;
        bit exp_sat, exp_neg;
        int waited;
        offset    = off;
        req_count = 0;
        saw_pos   = 0;
        saw_neg   = 0;
        short_gap = 0;
        if (off > 0) begin
            exp_neg = 1; exp_code = off;
        end else begin
            exp_neg = 0; exp_code = 1 - off;
        end
        exp_sat = exp_code > FULL;
        if (exp_sat) exp_code = FULL;
        exp_cmp = exp_code + 1;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        // R2: cleared, code 0, common-mode tied, no side
        check("R2 code", int'(code), 0);
        check("R2 short", int'(shrt), 1);
        check("R2 done", int'(done), 0);
        waited = 0;
        while (!done && waited < 3000) begin
            @(negedge clk);
            waited++;
            if (poke_start && waited == 20) start = 1'b1;   // R9
            else start = 1'b0;
        end
        start = 1'b0;
        check("watchdog", int'(done), 1);
        check("R5 R7 code", int'(code), exp_code);
        check("R7 sat", int'(sat), int'(exp_sat));
        check("R3 neg side", int'(saw_neg), int'(exp_neg));
        check("R3 pos side", int'(saw_pos), int'(!exp_neg));
        check("R4 compares", req_count, exp_cmp);
        check("R5 released", int'(spos || sneg || shrt), 0);
        check("R10 short during trim", int'(short_gap), 0);
        repeat (6) @(negedge clk);
        check("R6 hold code", int'(code), exp_code);
        check("R6 hold done", int'(done), 1);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        // R1: reset state
        check("R1 code", int'(code), 0);
        check("R1 flags", int'({req, shrt, spos, sneg, done, sat}), 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check("R1 idle", int'({req, shrt, spos, sneg, done, sat, code}), 0);
        // R8: strobes while idle change nothing
        noise_en = 1;
        repeat (10) @(negedge clk);
        noise_en = 0;
        check("R8 idle noise", int'({shrt, spos, sneg, done, sat, code}), 0);
        for (int o = -70; o <= 70; o++) run_one(o, 1'b0);
        // R9: start pulses mid-calibration
        run_one(40, 1'b1);
        run_one(-30, 1'b1);
        // R6: noise on strobe and outputs after done
        run_one(17, 1'b0);
        noise_en = 1;
        repeat (40) @(negedge clk);
        noise_en = 0;
        check("R6 noise code", int'(code), 17);
        check("R6 noise flags", int'({done, sat}), 2);
        // R2: restart after done gives fresh result
        run_one(-5, 1'b0);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        misses++;
        vectors++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

endmodule